// File: doc/BRIEF.md
# Signed Multiply Execution Unit

This unit carries out the multiply instructions of a 32-bit integer core. It decodes the instruction, selects the operands and computes a signed two's-complement product. It then returns up to two register write-backs with their destination indices. The register file stays outside the unit. On each start the core supplies the two halfwords of the instruction and the values of the two source registers. The first source register is indexed by bits 4..0 of the first halfword. The second is indexed by bits 15..11.

Four forms are supported:
- **Halfword register form:** multiplies the low halves of two registers.
- **Halfword 5-bit immediate form:** multiplies the low half of the second register by a sign-extended 5-bit immediate.
- **Halfword 16-bit immediate form:** multiplies the low half of the first register by a sign-extended 16-bit immediate.
- **Full-width forms:** multiply two 32-bit operands, or the second register and a sign-extended 9-bit immediate, into a 64-bit product.

The high word of a full-width product goes to a third register, named in the second halfword. The low word replaces the second source register.

The two halfword forms that use a register or the 5-bit immediate complete one cycle after start. The 16-bit immediate form and both full-width forms take two cycles. During those two cycles the unit raises busy for one cycle and refuses new work. No flags are produced.

Top module: `mul_unit`

## Requirements
- R1: With opcode 000111 in first-halfword bits 10..5, the unit multiplies sign-extended bits 15..0 of the two register values. It writes the 32-bit product on the low port to the index in first-halfword bits 15..11. Done rises one cycle after start, and busy stays low.
- R2: With opcode 010111, the factor is first-halfword bits 4..0 sign-extended, in place of the first register. Timing and write-back follow R1.
- R3: With opcode 110111, the unit multiplies sign-extended bits 15..0 of the first register by the sign-extended second halfword. It writes the 32-bit product on the low port to the second-register index. Busy is high in the cycle after start, and done follows one cycle later.
- R4: With opcode 111111 and second-halfword bits 10..0 equal to 0x220, the unit forms the 64-bit product of the two registers. The high word goes on the high port to the index in second-halfword bits 15..11. The low word goes on the low port to the second-register index. Timing follows R3.
- R5: With opcode 111111 the unit uses a 9-bit immediate when two fields hold fixed values: second-halfword bits 10..6 equal 01001 and bits 1..0 equal 00. The immediate is built from second-halfword bits 5..2 as bits 8..5 and first-halfword bits 4..0 as bits 4..0, then sign-extended. It multiplies the second register, with write-back and timing as in R4.
- R6: When a full-width form names the same index for the third and second registers, only the high-word write is issued.
- R7: A start that arrives while busy is high is ignored and produces no write-back.
- R8: A start whose encoding matches none of R1 to R5 raises neither busy nor done.
- R9: After reset, busy, done and both write enables are low.
- R10: Write enables are high only in a cycle where done is high. Done is low in any cycle that follows a cycle with neither start nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to execute the presented instruction |
| instr | input | 32 | Bits 15..0 first halfword, bits 31..16 second halfword |
| srcA | input | 32 | Value of the register indexed by first-halfword bits 4..0 |
| srcB | input | 32 | Value of the register indexed by first-halfword bits 15..11 |
| busy | output | 1 | Two-cycle operation in flight; start is refused |
| done | output | 1 | Write-back results valid this cycle |
| wrLoEn | output | 1 | Low-port write enable |
| wrLoIdx | output | 5 | Low-port destination index |
| wrLoData | output | 32 | Low-port data (halfword product or low product word) |
| wrHiEn | output | 1 | High-port write enable |
| wrHiIdx | output | 5 | High-port destination index |
| wrHiData | output | 32 | High-port data (high product word) |

## Verification
For the single-cycle halfword forms, the result is due at the first rising edge after start. The bench therefore samples at the following falling edge. For the 16-bit immediate and full-width forms, the bench first checks at the falling edge after the accepting edge that busy is high and done is low. It then samples the write-back one edge later. Ignored starts are checked by watching done and the enables at the falling edges after the point where a result would otherwise have appeared. Inputs change only on falling edges, so every sample falls half a period from the edge that produced it.

// File: rtl/mul_unit_pkg.sv
package mul_unit_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned PROD_W = 2 * WORD_W;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_HREG   = 6'b000111;
  localparam logic [OPC_W-1:0] OPC_HIMM5  = 6'b010111;
  localparam logic [OPC_W-1:0] OPC_HIMM16 = 6'b110111;
  localparam logic [OPC_W-1:0] OPC_WIDE   = 6'b111111;
  localparam logic [10:0]      SUB_WREG   = 11'h220;
  localparam logic [4:0]       SUB_WIMM   = 5'b01001;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_HREG,
    FORM_HIMM5,
    FORM_HIMM16,
    FORM_WREG,
    FORM_WIMM
  } mulForm_e;

  typedef struct packed {
    mulForm_e form;
    logic     capture;
    logic     emitLive;
    logic     emitHeld;
  } mulStrobe_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [10:0]      subField,
  output mulStrobe_t       strobe,
  output logic             busy
);
  mulForm_e form;
  logic     accept;
  logic     twoCycle;
  logic     busyQ;

  always_comb begin
    form = FORM_NONE;
    unique case (opcode)
      OPC_HREG:   form = FORM_HREG;
      OPC_HIMM5:  form = FORM_HIMM5;
      OPC_HIMM16: form = FORM_HIMM16;
      OPC_WIDE: begin
        if (subField == SUB_WREG)
          form = FORM_WREG;
        else if (subField[10:6] == SUB_WIMM && subField[1:0] == 2'b00)
          form = FORM_WIMM;
      end
      default: form = FORM_NONE;
    endcase
  end

  assign twoCycle = (form == FORM_HIMM16) || (form == FORM_WREG) || (form == FORM_WIMM);
  assign accept   = start && !busyQ && (form != FORM_NONE);

  always_comb begin
    strobe.form     = form;
    strobe.capture  = accept && twoCycle;
    strobe.emitLive = accept && !twoCycle;
    strobe.emitHeld = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= accept && twoCycle;
  end

  assign busy = busyQ;
endmodule

// File: rtl/mul_dp.sv
module mul_dp
  import mul_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strobe,
  input  logic [4:0]        immLo,
  input  logic [IDX_W-1:0]  reg2Idx,
  input  logic [HALF_W-1:0] hw1,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  output logic              done,
  output logic              wrLoEn,
  output logic [IDX_W-1:0]  wrLoIdx,
  output logic [WORD_W-1:0] wrLoData,
  output logic              wrHiEn,
  output logic [IDX_W-1:0]  wrHiIdx,
  output logic [WORD_W-1:0] wrHiData
);
  logic signed [WORD_W-1:0] liveX, liveY, heldX, heldY, mulX, mulY;
  logic signed [PROD_W-1:0] product;
  logic                     liveWide, heldWide, useWide;
  logic [IDX_W-1:0]         heldReg2, heldReg3, useReg2, useReg3;
  logic [8:0]               imm9;

  assign imm9 = {hw1[5:2], immLo};

  always_comb begin
    liveX    = WORD_W'($signed(srcA[HALF_W-1:0]));
    liveY    = WORD_W'($signed(srcB[HALF_W-1:0]));
    liveWide = 1'b0;
    case (strobe.form)
      FORM_HIMM5:  liveX = WORD_W'($signed(immLo));
      FORM_HIMM16: begin
        liveX = WORD_W'($signed(hw1));
        liveY = WORD_W'($signed(srcA[HALF_W-1:0]));
      end
      FORM_WREG: begin
        liveX    = srcA;
        liveY    = srcB;
        liveWide = 1'b1;
      end
      FORM_WIMM: begin
        liveX    = WORD_W'($signed(imm9));
        liveY    = srcB;
        liveWide = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldX    <= '0;
      heldY    <= '0;
      heldWide <= 1'b0;
      heldReg2 <= '0;
      heldReg3 <= '0;
    end else if (strobe.capture) begin
      heldX    <= liveX;
      heldY    <= liveY;
      heldWide <= liveWide;
      heldReg2 <= reg2Idx;
      heldReg3 <= hw1[15:11];
    end
  end

  assign mulX    = strobe.emitHeld ? heldX    : liveX;
  assign mulY    = strobe.emitHeld ? heldY    : liveY;
  assign useWide = strobe.emitHeld ? heldWide : liveWide;
  assign useReg2 = strobe.emitHeld ? heldReg2 : reg2Idx;
  assign useReg3 = strobe.emitHeld ? heldReg3 : hw1[15:11];
  assign product = PROD_W'(mulX) * PROD_W'(mulY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      wrLoEn   <= 1'b0;
      wrHiEn   <= 1'b0;
      wrLoIdx  <= '0;
      wrHiIdx  <= '0;
      wrLoData <= '0;
      wrHiData <= '0;
    end else begin
      done     <= strobe.emitLive || strobe.emitHeld;
      wrLoEn   <= 1'b0;
      wrHiEn   <= 1'b0;
      wrLoIdx  <= useReg2;
      wrHiIdx  <= useReg3;
      wrLoData <= product[WORD_W-1:0];
      wrHiData <= product[PROD_W-1:WORD_W];
      if (strobe.emitLive || strobe.emitHeld) begin
        wrHiEn <= useWide;
        wrLoEn <= !useWide || (useReg3 != useReg2);
      end
    end
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  output logic              busy,
  output logic              done,
  output logic              wrLoEn,
  output logic [IDX_W-1:0]  wrLoIdx,
  output logic [WORD_W-1:0] wrLoData,
  output logic              wrHiEn,
  output logic [IDX_W-1:0]  wrHiIdx,
  output logic [WORD_W-1:0] wrHiData
);
  mulStrobe_t strobe;

  mul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcode   (instr[10:5]),
    .subField (instr[26:16]),
    .strobe   (strobe),
    .busy     (busy)
  );

  mul_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .immLo    (instr[4:0]),
    .reg2Idx  (instr[15:11]),
    .hw1      (instr[31:16]),
    .srcA     (srcA),
    .srcB     (srcB),
    .done     (done),
    .wrLoEn   (wrLoEn),
    .wrLoIdx  (wrLoIdx),
    .wrLoData (wrLoData),
    .wrHiEn   (wrHiEn),
    .wrHiIdx  (wrHiIdx),
    .wrHiData (wrHiData)
  );
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wrLoEn,
  input logic [4:0] wrLoIdx,
  input logic       wrHiEn,
  input logic [4:0] wrHiIdx
);
  // R10
  en_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLoEn || wrHiEn) |-> done);

  // R10
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !busy) |=> !done);

  // R3
  busy_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R4
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done);

  // R6
  distinct_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLoEn && wrHiEn) |-> (wrLoIdx != wrHiIdx));
endmodule

bind mul_unit mul_unit_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .wrLoEn  (wrLoEn),
  .wrLoIdx (wrLoIdx),
  .wrHiEn  (wrHiEn),
  .wrHiIdx (wrHiIdx)
);

// File: tb/mul_unit_bench.sv
module mul_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        busy, done, wrLoEn, wrHiEn;
  logic [4:0]  wrLoIdx, wrHiIdx;
  logic [31:0] wrLoData, wrHiData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mul_unit u_mul_unit (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .srcA(srcA), .srcB(srcB),
    .busy(busy), .done(done), .wrLoEn(wrLoEn), .wrLoIdx(wrLoIdx), .wrLoData(wrLoData),
    .wrHiEn(wrHiEn), .wrHiIdx(wrHiIdx), .wrHiData(wrHiData)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  r1;
    logic [4:0]  r2;
    logic [5:0]  op;
    logic [15:0] hw1;
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  lat;
    logic        loEn;
    logic [31:0] lo;
    logic        hiEn;
    logic [4:0]  hiIdx;
    logic [31:0] hi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R1: 3 * -5, upper half of srcA ignored
    '{4'd1, 5'd1, 5'd2, 6'b000111, 16'h0000, 32'h0001_0003, 32'hFFFF_FFFB, 2'd1, 1'b1, 32'hFFFF_FFF1, 1'b0, 5'd0, 32'h0},
    // R1: 32767 * -32768
    '{4'd1, 5'd4, 5'd5, 6'b000111, 16'h0000, 32'h0000_7FFF, 32'h0000_8000, 2'd1, 1'b1, 32'hC000_8000, 1'b0, 5'd0, 32'h0},
    // R2: imm5 -16 * 256
    '{4'd2, 5'b10000, 5'd7, 6'b010111, 16'h0000, 32'h0, 32'h0000_0100, 2'd1, 1'b1, 32'hFFFF_F000, 1'b0, 5'd0, 32'h0},
    // R3: 16 * imm16 -2
    '{4'd3, 5'd8, 5'd9, 6'b110111, 16'hFFFE, 32'h1234_0010, 32'h5555_5555, 2'd2, 1'b1, 32'hFFFF_FFE0, 1'b0, 5'd0, 32'h0},
    // R4: -1 * 2
    '{4'd4, 5'd3, 5'd11, 6'b111111, {5'd10, 11'h220}, 32'hFFFF_FFFF, 32'h0000_0002, 2'd2, 1'b1, 32'hFFFF_FFFE, 1'b1, 5'd10, 32'hFFFF_FFFF},
    // R4: -2^31 * -2^31
    '{4'd4, 5'd6, 5'd13, 6'b111111, {5'd12, 11'h220}, 32'h8000_0000, 32'h8000_0000, 2'd2, 1'b1, 32'h0000_0000, 1'b1, 5'd12, 32'h4000_0000},
    // R5: imm9 -256 * 65536
    '{4'd5, 5'b00000, 5'd15, 6'b111111, {5'd14, 5'b01001, 4'b1000, 2'b00}, 32'h7777_7777, 32'h0001_0000, 2'd2, 1'b1, 32'hFF00_0000, 1'b1, 5'd14, 32'hFFFF_FFFF},
    // R5: imm9 +5 * 0x7FFFFFFF
    '{4'd5, 5'b00101, 5'd17, 6'b111111, {5'd16, 5'b01001, 4'b0000, 2'b00}, 32'h0, 32'h7FFF_FFFF, 2'd2, 1'b1, 32'h7FFF_FFFB, 1'b1, 5'd16, 32'h0000_0002}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    instr = ins;
    srcA  = a;
    srcB  = b;
    start = 1'b1;
  endtask

  task automatic runVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    present({v.hw1, v.r2, v.op, v.r1}, v.a, v.b);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (v.lat == 2'd2) begin
      chk(tag, "busy after accept", 32'(busy), 32'd1);
      chk(tag, "done before due", 32'(done), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end else begin
      chk(tag, "busy on short form", 32'(busy), 32'd0);
    end
    chk(tag, "done", 32'(done), 32'd1);
    chk(tag, "lo enable", 32'(wrLoEn), 32'(v.loEn));
    chk(tag, "lo index", 32'(wrLoIdx), 32'(v.r2));
    chk(tag, "lo data", wrLoData, v.lo);
    chk(tag, "hi enable", 32'(wrHiEn), 32'(v.hiEn));
    if (v.hiEn) begin
      chk(tag, "hi index", 32'(wrHiIdx), 32'(v.hiIdx));
      chk(tag, "hi data", wrHiData, v.hi);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9", "busy", 32'(busy), 32'd0);
    chk("R9", "done", 32'(done), 32'd0);
    chk("R9", "lo enable", 32'(wrLoEn), 32'd0);
    chk("R9", "hi enable", 32'(wrHiEn), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R6: third register equals second register, only the high word is written
    @(negedge clk);
    present({5'd20, 11'h220, 5'd20, 6'b111111, 5'd3}, 32'd2, 32'd3);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6", "done", 32'(done), 32'd1);
    chk("R6", "lo enable", 32'(wrLoEn), 32'd0);
    chk("R6", "hi enable", 32'(wrHiEn), 32'd1);
    chk("R6", "hi index", 32'(wrHiIdx), 32'd20);
    chk("R6", "hi data", wrHiData, 32'd0);

    // R7: start while busy is ignored
    @(negedge clk);
    present({5'd21, 11'h220, 5'd22, 6'b111111, 5'd1}, 32'd7, 32'd6);
    @(posedge clk); @(negedge clk);
    chk("R7", "busy", 32'(busy), 32'd1);
    present({16'h0, 5'd23, 6'b000111, 5'd1}, 32'd9, 32'd9);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R7", "first result data", wrLoData, 32'd42);
    chk("R7", "first result index", 32'(wrLoIdx), 32'd22);
    @(posedge clk); @(negedge clk);
    chk("R7", "no result for refused start", 32'(done), 32'd0);
    chk("R7", "no lo write for refused start", 32'(wrLoEn), 32'd0);

    // R8: unrecognized encodings
    present({5'd1, 11'h221, 5'd2, 6'b111111, 5'd3}, 32'd5, 32'd5);
    @(posedge clk); @(negedge clk);
    chk("R8", "busy on bad sub-field", 32'(busy), 32'd0);
    chk("R8", "done on bad sub-field", 32'(done), 32'd0);
    present({16'h0, 5'd2, 6'b000000, 5'd3}, 32'd5, 32'd5);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R8", "done on bad opcode", 32'(done), 32'd0);
    chk("R8", "lo enable on bad opcode", 32'(wrLoEn), 32'd0);
    @(posedge clk); @(negedge clk);
    // R10: idle cycle gives no done
    chk("R10", "idle done", 32'(done), 32'd0);
    chk("R10", "idle hi enable", 32'(wrHiEn), 32'd0);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule